// File: doc/BRIEF.md
# Serial Register and Parameter-Memory Access Port

This block is a four-wire serial slave that gives a host microcontroller full read and write access to an on-chip parameter memory and a small bank of control registers. A transaction is framed by an active-low latch input. The host shifts bits in on the rising edge of the serial clock. The block returns read data on the falling edge, so the host samples it on the next rising edge. Every field travels most-significant bit first.

Each transaction opens with a three-byte header:

- **First byte.** Bits 7:1 carry a 7-bit device identity and bit 0 carries the direction flag: 1 means read, 0 means write. The device answers to identity 0000000 when its strap input is low and to 0000001 when the strap is high. This lets two devices share one latch line.
- **Second byte.** The upper four bits are ignored. The lower four bits are subaddress bits 11:8.
- **Third byte.** Subaddress bits 7:0.

Data follows the header. The word width depends on the region the current subaddress falls in:

| Subaddress range | Region | Word width | Behaviour |
|---|---|---|---|
| 0x000–0x3FF | Parameter memory | 4 bytes | Read and write |
| 0x800–0x80F | Control registers | 2 bytes | Read and write |
| Anything else | Unmapped | 2 bytes | Writes dropped, reads return zero |

In a burst, the subaddress steps by one after every complete word, and the next word takes the width of the region the new subaddress lands in.

The serial output and its enable are two separate pins, so that a pad or a shared readback line can be tri-stated outside matched reads. The serial inputs are brought into the system clock domain through synchronisers. The system clock must therefore be at least eight times the serial clock rate.

There is no valid/ready stream at the block's edge. The serial side runs at the host's pace and is never back-pressured. The internal memory bus always accepts a word in the cycle it is offered.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset the output enable is 0, the serial output is 0, and every control register output reads 0.
- R2: A matched write to subaddress 0x000–0x3FF stores a 4-byte word, sent MSB first, that a later read of that subaddress returns unchanged.
- R3: A matched write to subaddress 0x800+n (n = 0..15) stores a 2-byte word that appears on ctrl_q bits [16n+15:16n]. The control register outputs change only through such a write.
- R4: In a burst, the subaddress advances by one after every complete word, and each word takes the width of the region of its own subaddress, for both writes and reads.
- R5: A transaction whose identity bits 7:1 differ from {6'b0, addr_sel} writes nothing and never enables the serial output.
- R6: In a matched read, the output enable rises at the start of byte 3. Data then leaves MSB first, one bit per serial clock cycle, across all words of the burst.
- R7: A write word is committed only when its last byte has arrived. If the latch rises mid-word, that word is discarded, and the next transaction starts again from the header.
- R8: Writes to unmapped subaddresses change nothing, and reads of them return zero over 2-byte words.
- R9: The output enable stays 0 during the header and in write transactions, and it returns to 0 once the latch is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap selecting device identity 0 or 1 |
| spi_latch_n | input | 1 | Active-low transaction frame |
| spi_sck | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data to the host, valid while spi_miso_oe is 1 |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| ctrl_q | output | 256 | Control register contents, register n in bits [16n+15:16n] |

## Verification
A wrong header state, such as a bad byte index or a stale identity match, shows up within that same transaction: the output enable rises at the wrong bit, or read data arrives shifted. A wrong word-width or address counter shows up in the following read-back of the burst, as words that land on the wrong subaddress or are split across the region boundary. A counter that survives a latch rise corrupts the very next transaction's header, and the next read then returns data from the wrong location.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int SUB_W       = 12;
  localparam int PRAM_WORDS  = 1024;
  localparam int PRAM_W      = 32;
  localparam int CTRL_N      = 16;
  localparam int CTRL_W      = 16;
  localparam logic [7:0] CTRL_PAGE = 8'h80;

  typedef enum logic [1:0] {RG_PRAM, RG_CTRL, RG_NONE} region_e;

  function automatic region_e region_of(input logic [SUB_W-1:0] a);
    if (32'(a) < PRAM_WORDS) return RG_PRAM;
    else if (a[SUB_W-1:4] == CTRL_PAGE) return RG_CTRL;
    else return RG_NONE;
  endfunction

  function automatic logic [2:0] word_bytes(input region_e r);
    return (r == RG_PRAM) ? 3'd4 : 3'd2;
  endfunction
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st[g] <= RST_VAL;
      else        st[g] <= st[g-1];
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_ctl_regfile.sv
module spi_ctl_regfile
  import spi_ctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SUB_W-1:0]         wr_addr,
  input  logic [PRAM_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic [SUB_W-1:0]         rd_addr,
  output logic                     rd_valid,
  output logic [PRAM_W-1:0]        rd_data,
  output logic [CTRL_N*CTRL_W-1:0] ctrl_q
);
  localparam int PA_W = $clog2(PRAM_WORDS);
  localparam int CA_W = $clog2(CTRL_N);

  logic [PRAM_W-1:0] pram [PRAM_WORDS];
  logic [CTRL_W-1:0] ctrl [CTRL_N];
  logic [PRAM_W-1:0] pram_rd;
  region_e           rd_reg_q;
  logic [CTRL_W-1:0] ctrl_rd_q;

  region_e wr_reg, rd_reg;
  assign wr_reg = region_of(wr_addr);
  assign rd_reg = region_of(rd_addr);

  always_ff @(posedge clk)
    if (wr_en && wr_reg == RG_PRAM) pram[wr_addr[PA_W-1:0]] <= wr_data;

  always_ff @(posedge clk)
    if (rd_en) pram_rd <= pram[rd_addr[PA_W-1:0]];

  for (genvar n = 0; n < CTRL_N; n++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ctrl[n] <= '0;
      else if (wr_en && wr_reg == RG_CTRL && wr_addr[CA_W-1:0] == CA_W'(n))
        ctrl[n] <= wr_data[CTRL_W-1:0];
    assign ctrl_q[n*CTRL_W +: CTRL_W] = ctrl[n];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_reg_q  <= RG_NONE;
      ctrl_rd_q <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_reg_q  <= rd_reg;
        ctrl_rd_q <= ctrl[rd_addr[CA_W-1:0]];
      end
    end

  always_comb
    case (rd_reg_q)
      RG_PRAM: rd_data = pram_rd;
      RG_CTRL: rd_data = {{(PRAM_W-CTRL_W){1'b0}}, ctrl_rd_q};
      default: rd_data = '0;
    endcase

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
  p_unmapped_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == RG_NONE) |=> $stable(ctrl_q));
endmodule

// File: rtl/spi_ctl_frame.sv
module spi_ctl_frame
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              sck_s,
  input  logic              lat_s,
  input  logic              mosi_s,
  output logic              wr_en,
  output logic [SUB_W-1:0]  wr_addr,
  output logic [PRAM_W-1:0] wr_data,
  output logic              rd_en,
  output logic [SUB_W-1:0]  rd_addr,
  input  logic              rd_valid,
  input  logic [PRAM_W-1:0] rd_data,
  output logic              miso,
  output logic              miso_oe
);
  logic              sck_d;
  logic [2:0]        bit_cnt;
  logic [6:0]        sh_q;
  logic [1:0]        byte_idx;
  logic              id_ok, rw_q;
  logic [SUB_W-1:0]  addr_q;
  logic [1:0]        wbyte;
  logic [23:0]       wbuf;
  logic [PRAM_W-1:0] tx_sh;
  logic              tx_fresh;

  logic       active, rise, fall, word_end;
  logic [7:0] nb;
  logic [2:0] wlen;
  logic [SUB_W-1:0] addr_nx;

  assign active   = !lat_s;
  assign rise     = sck_s && !sck_d;
  assign fall     = !sck_s && sck_d;
  assign nb       = {sh_q, mosi_s};
  assign wlen     = word_bytes(region_of(addr_q));
  assign word_end = ({1'b0, wbyte} == wlen - 3'd1);
  assign addr_nx  = addr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; sh_q <= '0; byte_idx <= '0; id_ok <= 1'b0; rw_q <= 1'b0;
      addr_q <= '0; wbyte <= '0; wbuf <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      rd_en <= 1'b0; rd_addr <= '0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (!active) begin
        bit_cnt <= '0; byte_idx <= '0; id_ok <= 1'b0; rw_q <= 1'b0;
        wbyte <= '0; wbuf <= '0;
      end else if (rise) begin
        sh_q    <= nb[6:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          case (byte_idx)
            2'd0: begin
              id_ok    <= (nb[7:1] == {6'b0, addr_sel});
              rw_q     <= nb[0];
              byte_idx <= 2'd1;
            end
            2'd1: begin
              addr_q[SUB_W-1:8] <= nb[3:0];
              byte_idx          <= 2'd2;
            end
            2'd2: begin
              addr_q[7:0] <= nb;
              byte_idx    <= 2'd3;
              if (id_ok && rw_q) begin
                rd_en   <= 1'b1;
                rd_addr <= {addr_q[SUB_W-1:8], nb};
              end
            end
            default: begin
              wbuf <= {wbuf[15:0], nb};
              if (word_end) begin
                wbyte  <= '0;
                addr_q <= addr_nx;
                if (id_ok && !rw_q) begin
                  wr_en   <= 1'b1;
                  wr_addr <= addr_q;
                  wr_data <= {wbuf, nb};
                end
                if (id_ok && rw_q) begin
                  rd_en   <= 1'b1;
                  rd_addr <= addr_nx;
                end
              end else begin
                wbyte <= wbyte + 1'b1;
              end
            end
          endcase
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '0; tx_fresh <= 1'b0; miso_oe <= 1'b0;
    end else if (!active) begin
      tx_sh <= '0; tx_fresh <= 1'b0; miso_oe <= 1'b0;
    end else if (rd_valid) begin
      tx_sh    <= (region_of(rd_addr) == RG_PRAM) ? rd_data
                                                  : {rd_data[15:0], 16'h0};
      tx_fresh <= 1'b1;
    end else if (fall) begin
      if (tx_fresh) begin
        tx_fresh <= 1'b0;
        miso_oe  <= 1'b1;
      end else if (miso_oe) begin
        tx_sh <= {tx_sh[PRAM_W-2:0], 1'b0};
      end
    end

  assign miso = miso_oe && tx_sh[PRAM_W-1];

  p_oe_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !miso_oe);
  p_oe_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> (rw_q && id_ok && byte_idx == 2'd3));
  p_wr_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (id_ok && !rw_q));
  p_wr_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(active));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && active) |-> (addr_q == wr_addr + 1'b1));
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     addr_sel,
  input  logic                     spi_latch_n,
  input  logic                     spi_sck,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  output logic                     spi_miso_oe,
  output logic [CTRL_N*CTRL_W-1:0] ctrl_q
);
  logic [2:0]        pins_s;
  logic              wr_en, rd_en, rd_valid;
  logic [SUB_W-1:0]  wr_addr, rd_addr;
  logic [PRAM_W-1:0] wr_data, rd_data;

  spi_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_latch_n, spi_sck, spi_mosi}), .q(pins_s)
  );

  spi_ctl_frame u_frame (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .sck_s(pins_s[1]), .lat_s(pins_s[2]), .mosi_s(pins_s[0]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_ctl_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .ctrl_q(ctrl_q)
  );
endmodule

// File: tb/spi_ctl_port_test.sv
module spi_ctl_port_test;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, addr_sel = 1'b0;
  logic latch_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic [255:0] ctrl_q;

  int n_vec = 0, n_bad = 0;
  logic [7:0]  txb [64];
  logic [7:0]  rxb [64];
  logic        oe_hdr, oe_all_data;
  logic [31:0] m_pram [1024];
  logic [15:0] m_ctrl [16];
  logic [31:0] wd [16];

  always #4 clk = ~clk;

  spi_ctl_port uut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .spi_latch_n(latch_n),
    .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .ctrl_q(ctrl_q)
  );

  function automatic int wbytes(input logic [11:0] a);
    return (a < 12'h400) ? 4 : 2;
  endfunction

  function automatic logic [31:0] model_rd(input logic [11:0] a);
    if (a < 12'h400) return m_pram[a[9:0]];
    if (a[11:4] == 8'h80) return {16'h0, m_ctrl[a[3:0]]};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift nbytes out; abort_bits>0 raises latch after that many bits.
  task automatic xfer(input int nbytes, input int abort_bits);
    int bits = 0;
    oe_hdr = 1'b0; oe_all_data = 1'b1;
    latch_n = 1'b0; tick(HALF);
    for (int b = 0; b < nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (abort_bits > 0 && bits == abort_bits) break;
        mosi = txb[b][i];
        tick(HALF);
        rxb[b][i] = miso;
        if (b < 3 && miso_oe) oe_hdr = 1'b1;
        if (b >= 3 && !miso_oe) oe_all_data = 1'b0;
        sck = 1'b1; tick(HALF);
        sck = 1'b0;
        bits++;
      end
    end
    tick(HALF);
    latch_n = 1'b1;
    tick(3*HALF);
  endtask

  task automatic hdr(input logic [6:0] id, input logic rd, input logic [11:0] a);
    txb[0] = {id, rd}; txb[1] = {4'h0, a[11:8]}; txb[2] = a[7:0];
  endtask

  // Burst write of nw words from wd[], updating the model when it should land.
  task automatic wr_burst(input logic [6:0] id, input logic [11:0] a0, input int nw);
    int p = 3;
    logic [11:0] a = a0;
    hdr(id, 1'b0, a0);
    for (int w = 0; w < nw; w++) begin
      int nb = wbytes(a);
      for (int k = nb-1; k >= 0; k--) begin txb[p] = wd[w][8*k +: 8]; p++; end
      if (id == {6'b0, addr_sel}) begin
        if (a < 12'h400) m_pram[a[9:0]] = wd[w];
        else if (a[11:4] == 8'h80) m_ctrl[a[3:0]] = wd[w][15:0];
      end
      a = a + 12'd1;
    end
    xfer(p, 0);
  endtask

  task automatic rd_burst(input string req, input logic [11:0] a0, input int nw);
    int p = 3;
    logic [11:0] a = a0;
    int nbt = 3;
    for (int w = 0; w < nw; w++) begin nbt += wbytes(a); a = a + 12'd1; end
    hdr({6'b0, addr_sel}, 1'b1, a0);
    for (int i = 3; i < nbt; i++) txb[i] = 8'hA5;
    xfer(nbt, 0);
    chk({req, " R9 oe in header"}, {31'b0, oe_hdr}, 32'h0);
    chk({req, " R6 oe over data"}, {31'b0, oe_all_data}, 32'h1);
    a = a0;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] got = '0;
      for (int k = 0; k < wbytes(a); k++) begin got = {got[23:0], rxb[p]}; p++; end
      chk(req, got, model_rd(a));
      a = a + 12'd1;
    end
    chk({req, " R9 oe after latch"}, {31'b0, miso_oe}, 32'h0);
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) m_ctrl[i] = '0;
    tick(4); rst_n = 1'b1; tick(4);
    // R1 reset state
    chk("R1 oe", {31'b0, miso_oe}, 32'h0);
    chk("R1 miso", {31'b0, miso}, 32'h0);
    chk("R1 ctrl", {31'b0, |ctrl_q}, 32'h0);

    // R2 single param word, R6 MSB-first read
    wd[0] = 32'hDEADBEEF; wr_burst(7'd0, 12'h005, 1);
    rd_burst("R2 R6 param single", 12'h005, 1);

    // R3 control register visible on ctrl_q
    wd[0] = 32'h0000_1234; wr_burst(7'd0, 12'h803, 1);
    chk("R3 ctrl_q slice", {16'h0, ctrl_q[3*16 +: 16]}, 32'h1234);
    chk("R3 other regs", {31'b0, |(ctrl_q & ~(256'hFFFF << 48))}, 32'h0);

    // R4 R8 burst crossing param end into unmapped
    wd[0] = 32'h11112222; wd[1] = 32'h33334444; wd[2] = 32'h00005555; wd[3] = 32'h00006666;
    wr_burst(7'd0, 12'h3FE, 4);
    rd_burst("R4 R8 cross param", 12'h3FE, 4);
    wd[0] = 32'h0000AAAA; wd[1] = 32'h0000BBBB; wd[2] = 32'h0000CCCC;
    wr_burst(7'd0, 12'h80E, 3);
    rd_burst("R4 R8 cross ctrl", 12'h80E, 3);
    chk("R8 ctrl untouched", {16'h0, ctrl_q[0 +: 16]}, 32'h0);

    // R5 identity mismatch, strap low then high
    wd[0] = 32'hCAFEF00D; wr_burst(7'd1, 12'h005, 1);
    rd_burst("R5 mismatch write", 12'h005, 1);
    hdr(7'd1, 1'b1, 12'h005); xfer(7, 0);
    chk("R5 oe on mismatched read", {31'b0, oe_all_data}, 32'h0);
    addr_sel = 1'b1;
    wd[0] = 32'h0BADC0DE; wr_burst(7'd1, 12'h006, 1);
    wd[0] = 32'h77777777; wr_burst(7'd0, 12'h006, 1);
    rd_burst("R5 strap high", 12'h006, 1);
    addr_sel = 1'b0;

    // R7 partial word discarded
    wd[0] = 32'h01020304; wr_burst(7'd0, 12'h010, 1);
    wd[0] = 32'h0A0B0C0D; wd[1] = 32'h0E0F1011;
    hdr(7'd0, 1'b0, 12'h010);
    txb[3] = 8'h99; txb[4] = 8'h98; txb[5] = 8'h97; txb[6] = 8'h96;
    txb[7] = 8'h55; txb[8] = 8'h66; txb[9] = 8'h77;
    m_pram[12'h010] = 32'h99989796;
    xfer(10, 8*8 + 3);
    rd_burst("R7 partial drop", 12'h010, 2);

    // Random bursts
    for (int it = 0; it < 24; it++) begin
      logic [11:0] a;
      int nw = 1 + ($urandom % 4);
      if ($urandom % 2) a = 12'($urandom % 1020);
      else a = 12'h800 + 12'($urandom % 12);
      for (int w = 0; w < nw; w++) wd[w] = $urandom;
      wr_burst(7'd0, a, nw);
      rd_burst("R2 R3 R4 random", a, nw);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule